// File: doc/BRIEF.md
# Streaming AES Round-Key Generator

This block expands an AES cipher key into its round keys while the cipher runs, handing over one 128-bit round key in every clock cycle. It keeps no table of expanded keys. A data path that consumes one round per cycle can take the output directly. The block accepts 128-, 192- and 256-bit keys.

A start pulse latches the key and the length select. From the next cycle the block presents round key 0, then round key 1, and so on up to the final round. During that sequence a valid flag stays high and a round counter runs alongside the keys.

The 192- and 256-bit schedules grow in six-word and eight-word steps, while the output takes four words per cycle. To cover this, the block keeps an eight-word sliding window and computes four new words in each cycle. A small phase machine drives seven select lines:

- four lines place the rotate, substitute and round-constant step on the correct one of the four new words;
- one line applies a plain word substitution;
- two lines choose which four words of the window go out.

Top module: `aes_round_key_gen`

## Requirements
- R1: `key_len` selects the key size: 2'b00 is 128 bits, 2'b01 is 192 bits, and 2'b10 or 2'b11 is 256 bits. The key occupies the most significant bits of `key_in`, and word 0 of the key is `key_in[255:224]`.
- R2: When `start` is sampled high while the block is idle, the next cycle shows `rk_valid` high, `rk_index` 0, and `rk_out` equal to the first four key words, with word 0 in `rk_out[127:96]`.
- R3: With a 128-bit key, round key r is expansion words 4r..4r+3. Each word that starts a four-word group gets a rotate, a byte substitution and a round constant. The round constants run 01, 02, 04, 08, 10, 20, 40, 80, 1b, 36 and are XORed into the top byte.
- R4: With a 192-bit key, the expanded words match the standard schedule. Here the rotate, substitute and constant step falls on every sixth word, so within a cycle it can land on any of several word positions.
- R5: With a 256-bit key, the expanded words match the standard schedule. A word at index i with i mod 8 = 4 gets byte substitution only, with no rotation and no round constant.
- R6: `rk_valid` stays high for exactly 11, 13 or 15 consecutive cycles for 128-, 192- and 256-bit keys, and then falls.
- R7: While `rk_valid` is high, `rk_index` starts at 0 and rises by one each cycle up to 10, 12 or 14. While `rk_valid` is low, `rk_index` is 0.
- R8: A `start` pulse that arrives while keys are being emitted has no effect on the keys, the index or the length of the sequence.
- R9: After reset, `rk_valid` is low and `rk_index` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new expansion when idle |
| key_len | input | 2 | Key size select |
| key_in | input | 256 | Cipher key, left-aligned |
| rk_valid | output | 1 | Round key on `rk_out` is valid |
| rk_index | output | 4 | Round number of the current key |
| rk_out | output | 128 | Current round key |

## Verification
The hardest case is the 192-bit schedule. There, the round-constant word falls at a different position within the four-word output on successive cycles, and one cycle in every three has no transform at all. Only a full run of 13 keys passes through every phase. The bench therefore applies many random 192-bit keys alongside the standard test keys, and compares every emitted word against a reference that expands the key word by word. A second start is injected in the middle of some runs, so that any wrongly accepted restart would show up as a corrupted key or a truncated sequence.

// File: rtl/aes_round_key_gen.sv
module aes_round_key_gen (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   key_len,
  input  logic [255:0] key_in,
  output logic         rk_valid,
  output logic [3:0]   rk_index,
  output logic [127:0] rk_out
);

  localparam int WIN = 8;
  localparam int LANES = 4;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] t, r;
    t = x;
    r = 8'h01;
    for (int k = 1; k < 8; k++) begin
      t = gf_mul(t, t);
      r = gf_mul(r, t);
    end
    return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]} ^ {r[3:0], r[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [31:0] sub_word(input logic [31:0] w);
    return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
  endfunction

  logic [1:0]  klen;
  logic        busy;
  logic [3:0]  round;
  logic [1:0]  phase;
  logic [7:0]  rcon;
  logic [31:0] hist [WIN];
  logic [31:0] nxt  [LANES];
  logic [31:0] keyw [WIN];

  wire is192 = (klen == 2'b01);
  wire is256 = klen[1];
  wire [3:0] last_round = is256 ? 4'd14 : (is192 ? 4'd12 : 4'd10);

  logic [6:0] sel;
  wire [3:0] sel_full = sel[3:0];
  wire       sel_sub  = sel[4];
  wire [1:0] sel_win  = sel[6:5];
  wire [2:0] base     = {sel_win, 1'b0};

  always_comb begin
    if (is256)
      sel = {2'd0, phase == 2'd1, (phase == 2'd0) ? 4'b0001 : 4'b0000};
    else if (is192)
      sel = {2'd1, 1'b0, (phase == 2'd0) ? 4'b0001 : (phase == 2'd1) ? 4'b0100 : 4'b0000};
    else
      sel = {2'd2, 1'b0, 4'b0001};
  end

  wire [1:0] ld_win = key_len[1] ? 2'd0 : (key_len == 2'b01 ? 2'd1 : 2'd2);
  wire [2:0] ld_base = {ld_win, 1'b0};

  always_comb begin
    for (int m = 0; m < WIN; m++)
      keyw[m] = key_in[255 - 32*m -: 32];
  end

  always_comb begin
    logic [31:0] prev, t;
    prev = hist[WIN-1];
    for (int j = 0; j < LANES; j++) begin
      if (sel_full[j])
        t = sub_word({prev[23:0], prev[31:24]}) ^ {rcon, 24'h0};
      else if (j == 0 && sel_sub)
        t = sub_word(prev);
      else
        t = prev;
      nxt[j] = hist[base + 3'(j)] ^ t;
      prev = nxt[j];
    end
  end

  assign rk_out   = {hist[base], hist[base + 3'd1], hist[base + 3'd2], hist[base + 3'd3]};
  assign rk_valid = busy;
  assign rk_index = round;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      klen  <= 2'b00;
      busy  <= 1'b0;
      round <= 4'd0;
      phase <= 2'd0;
      rcon  <= 8'h01;
      for (int p = 0; p < WIN; p++) hist[p] <= 32'h0;
    end else if (!busy) begin
      if (start) begin
        klen  <= key_len;
        busy  <= 1'b1;
        round <= 4'd0;
        phase <= 2'd0;
        rcon  <= 8'h01;
        for (int p = 0; p < WIN; p++)
          hist[p] <= (3'(p) >= ld_base) ? keyw[3'(p) - ld_base] : 32'h0;
      end
    end else begin
      for (int p = 0; p < LANES; p++) begin
        hist[p]         <= hist[p + LANES];
        hist[p + LANES] <= nxt[p];
      end
      if (|sel_full) rcon <= {rcon[6:0], 1'b0} ^ (rcon[7] ? 8'h1b : 8'h00);
      if (is256)      phase <= {1'b0, ~phase[0]};
      else if (is192) phase <= (phase == 2'd2) ? 2'd0 : phase + 2'd1;
      else            phase <= 2'd0;
      if (round == last_round) begin
        busy  <= 1'b0;
        round <= 4'd0;
      end else begin
        round <= round + 4'd1;
      end
    end
  end

endmodule

// File: rtl/aes_round_key_gen_chk.sv
module aes_round_key_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       rk_valid,
  input logic [3:0] rk_index
);

  // R7
  idle_index_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rk_valid |-> rk_index == 4'd0);

  // R7
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rk_valid && $past(rk_valid)) |-> rk_index == $past(rk_index) + 4'd1);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !rk_valid) |=> (rk_valid && rk_index == 4'd0));

  // R6
  end_of_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rk_valid) |-> ($past(rk_index) == 4'd10 || $past(rk_index) == 4'd12 || $past(rk_index) == 4'd14));

  // R7
  index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rk_valid |-> rk_index <= 4'd14);

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && rk_valid && rk_index != 4'd10 && rk_index != 4'd12 && rk_index != 4'd14) |=> rk_index != 4'd0);

endmodule

bind aes_round_key_gen aes_round_key_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rk_valid(rk_valid), .rk_index(rk_index)
);

// File: tb/sim_aes_round_key_gen.sv
module sim_aes_round_key_gen;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   key_len = 2'b00;
  logic [255:0] key_in = '0;
  logic         rk_valid;
  logic [3:0]   rk_index;
  logic [127:0] rk_out;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [7:0]   sbt [256];
  logic [31:0]  rw [60];
  logic [127:0] last_rk;

  always #4 clk = ~clk;

  aes_round_key_gen u0 (.clk(clk), .rst_n(rst_n), .start(start), .key_len(key_len),
                        .key_in(key_in), .rk_valid(rk_valid), .rk_index(rk_index), .rk_out(rk_out));

  function automatic logic [7:0] mulb(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, aa, bb;
    acc = 0; aa = a; bb = b;
    while (bb != 0) begin
      if (bb[0]) acc ^= aa;
      aa = aa[7] ? ((aa << 1) ^ 8'h1b) : (aa << 1);
      bb = bb >> 1;
    end
    return acc;
  endfunction

  function automatic logic [31:0] sw(input logic [31:0] w);
    return {sbt[w[31:24]], sbt[w[23:16]], sbt[w[15:8]], sbt[w[7:0]]};
  endfunction

  function automatic logic [7:0] rc_of(input int n);
    logic [7:0] r;
    r = 8'h01;
    for (int k = 1; k < n; k++) r = mulb(r, 8'h02);
    return r;
  endfunction

  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv, b;
      inv = 8'h00;
      for (int y = 1; y < 256; y++) if (mulb(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      b = 8'h00;
      for (int i = 0; i < 8; i++)
        b[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
      sbt[x] = b ^ 8'h63;
    end
  endtask

  task automatic build_ref(input logic [255:0] k, input int nk);
    for (int i = 0; i < 60; i++) begin
      logic [31:0] t;
      if (i < nk) rw[i] = k[255 - 32*i -: 32];
      else begin
        t = rw[i-1];
        if (i % nk == 0) t = sw({t[23:0], t[31:24]}) ^ {rc_of(i / nk), 24'h0};
        else if (nk == 8 && i % nk == 4) t = sw(t);
        rw[i] = rw[i-nk] ^ t;
      end
    end
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [255:0] key, input logic [1:0] lc, input bit intrude);
    int nk, nr;
    string rq;
    nk = lc[1] ? 8 : (lc == 2'b01 ? 6 : 4);
    nr = nk + 6;
    rq = (nk == 4) ? "R3" : (nk == 6) ? "R4" : "R5";
    build_ref(key, nk);
    @(negedge clk);
    key_in = key; key_len = lc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: first key is the top four key words
    chk("R2", rk_out, key[255:128]);
    for (int r = 0; r <= nr; r++) begin
      if (r > 0) @(negedge clk);
      if (intrude && r == 3) begin start = 1'b1; key_in = ~key; key_len = lc + 2'd1; end
      if (intrude && r == 4) start = 1'b0;
      chk("R6", 128'(rk_valid), 128'd1);
      chk("R7", 128'(rk_index), 128'(r));
      chk(intrude ? "R8" : rq, rk_out, {rw[4*r], rw[4*r+1], rw[4*r+2], rw[4*r+3]});
      last_rk = rk_out;
    end
    @(negedge clk);
    chk("R6", 128'(rk_valid), 128'd0);
    chk("R7", 128'(rk_index), 128'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc >= 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [255:0] k;
    void'($urandom(32'd4242));
    build_sbox();
    repeat (3) @(negedge clk);
    // R9
    chk("R9", 128'(rk_valid), 128'd0);
    chk("R9", 128'(rk_index), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", 128'(rk_valid), 128'd0);

    run({128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0}, 2'b00, 1'b0);
    chk("R3", last_rk, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    run({192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 64'h0}, 2'b01, 1'b0);
    chk("R4", last_rk, 128'he98ba06f448c773c8ecc720401002202);
    run(256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4, 2'b10, 1'b0);
    chk("R5", last_rk, 128'hfe4890d1e6188d0b046df344706c631e);
    // R1: code 2'b11 also selects 256 bits
    run(256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4, 2'b11, 1'b0);
    chk("R1", last_rk, 128'hfe4890d1e6188d0b046df344706c631e);
    run('0, 2'b01, 1'b0);
    run('1, 2'b10, 1'b0);

    for (int n = 0; n < 60; n++) begin
      k = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      run(k, 2'($urandom % 4), (n % 5) == 2);
    end
    for (int n = 0; n < 15; n++) begin
      k = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      run(k, 2'b01, n[0]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule